// File: doc/BRIEF.md
# Configuration Image Header Inspector

This block sits beside the data path that streams a configuration image, one 32-bit word per accepted cycle, into a target device. It does not alter the stream. It counts the words of each image and reads two flags from header words at fixed indices. One flag shows whether the image is encrypted and the other whether it is compressed. From these flags and the selected bus width (16 or 32 bits) it produces the 2-bit clock-to-data ratio code that the configuration clocking must use.

An image opens with a start strobe and closes with an end strobe. When the compression word arrives, the block issues the ratio code with a one-cycle valid strobe. If the image closes before that word, the block pulses an error instead. Downstream logic latches the code on the valid strobe. It aborts the load on the error.

Top module: `cfg_hdr_inspect`

## Requirements
- R1: While reset is low, and in the first cycle after it, `ratio_o` is 0 and both `ratio_vld_o` and `err_o` are low.
- R2: A word is accepted only in a cycle where `valid_i` is high and an image is open. `sof_i` opens an image, and a word accepted in the `sof_i` cycle has index 0. Each later accepted word has the next index, and idle cycles do not advance the index.
- R3: The image counts as encrypted when bits 3:2 of the word at index 69 are not both zero. Every other bit of that word is ignored.
- R4: The image counts as compressed when bit 1 of the word at index 229 is 0.
- R5: The ratio code is 0 (x1) when the image is neither encrypted nor compressed. It is 2 (x4) for a compressed image at 16-bit width and 3 (x8) at 32-bit width. It is 1 (x2) for an image that is encrypted and not compressed at 16-bit width, and 2 (x4) at 32-bit width.
- R6: `ratio_vld_o` is high for exactly one cycle, the cycle after word 229 is accepted. `ratio_o` carries the new code in that cycle and holds it until the next valid strobe.
- R7: If `eof_i` arrives while an image is open and word 229 has not been accepted, `err_o` is high for one cycle, the cycle after `eof_i`, and no valid strobe is issued for that image.
- R8: When `eof_i` falls in the same cycle as the accepted word 229, the image is complete. The block issues the ratio and no error.
- R9: Words after index 229, an `eof_i` after a complete image, and an `eof_i` with no open image all leave `ratio_o` unchanged and raise neither strobe.
- R10: `wide_i` (1 = 32-bit, 0 = 16-bit) is sampled only in the cycle of word 229. Its value in other cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start of image, opens an image and restarts the index |
| eof_i | input | 1 | End of image, closes the open image |
| valid_i | input | 1 | `data_i` carries an image word this cycle |
| data_i | input | 32 | Image word |
| wide_i | input | 1 | Bus width select, 1 = 32-bit, 0 = 16-bit |
| ratio_o | output | 2 | Ratio code: 0 = x1, 1 = x2, 2 = x4, 3 = x8 |
| ratio_vld_o | output | 1 | One-cycle strobe marking a new `ratio_o` |
| err_o | output | 1 | One-cycle strobe for an image too short to hold the header |

## Verification
Completion and truncation can meet in one cycle, when the end strobe comes with the compression word itself. The bench closes a 230-word image with `eof_i` on word 229 and requires a valid strobe, the right code and no error. It also closes a 229-word image with `eof_i` on its last word and requires the error with no valid strobe. Both outcomes are judged at the edge after that word, together with the index at which the valid strobe appeared.

// File: rtl/cfg_hdr_inspect_pkg.sv
package cfg_hdr_inspect_pkg;
  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;
endpackage

// File: rtl/word_idx_ctr.sv
module word_idx_ctr #(
  parameter int SAT   = 230,
  parameter int CNT_W = $clog2(SAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic             valid_i,
  output logic             active_o,
  output logic             accept_o,
  output logic [CNT_W-1:0] idx_o
);
  logic             open_q;
  logic [CNT_W-1:0] cnt_q;

  assign active_o = sof_i | open_q;
  assign accept_o = valid_i & active_o;
  assign idx_o    = sof_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      // eof closes even a one-word image opened in the same cycle
      if (eof_i)      open_q <= 1'b0;
      else if (sof_i) open_q <= 1'b1;
      if (accept_o)
        cnt_q <= (idx_o < CNT_W'(SAT)) ? idx_o + 1'b1 : CNT_W'(SAT);
      else if (sof_i)
        cnt_q <= '0;
    end
  end

  // R2
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && open_q && !sof_i && cnt_q < CNT_W'(SAT)) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R9
  idx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SAT));
endmodule

// File: rtl/hdr_field_cap.sv
module hdr_field_cap #(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_BIT = 1,
  parameter int CNT_W   = $clog2(CMP_IDX + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              accept_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              enc_o,
  output logic              cmp_hit_o,
  output logic              cmp_o
);
  logic enc_q;
  logic enc_hit;

  assign enc_hit   = accept_i && (idx_i == CNT_W'(ENC_IDX));
  assign cmp_hit_o = accept_i && (idx_i == CNT_W'(CMP_IDX));
  // compression flag is active low in the image
  assign cmp_o     = ~data_i[CMP_BIT];
  assign enc_o     = enc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      enc_q <= 1'b0;
    else if (enc_hit) enc_q <= |data_i[ENC_LSB +: ENC_W];
    else if (sof_i)   enc_q <= 1'b0;
  end

  // R3
  enc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept_i && !sof_i) |=> $stable(enc_q));
endmodule

// File: rtl/ratio_map.sv
module ratio_map
  import cfg_hdr_inspect_pkg::*;
(
  input  logic   enc_i,
  input  logic   cmp_i,
  input  logic   wide_i,
  output ratio_e ratio_o
);
  logic [1:0] base;

  always_comb begin
    if (cmp_i)      base = 2'(RATIO_X4);
    else if (enc_i) base = 2'(RATIO_X2);
    else            base = 2'(RATIO_X1);
    // 32-bit width doubles every ratio above x1
    if (wide_i && (cmp_i || enc_i)) ratio_o = ratio_e'(base + 2'd1);
    else                            ratio_o = ratio_e'(base);
  end
endmodule

// File: rtl/cfg_hdr_inspect.sv
module cfg_hdr_inspect
  import cfg_hdr_inspect_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wide_i,
  output logic [1:0]        ratio_o,
  output logic              ratio_vld_o,
  output logic              err_o
);
  localparam int SAT   = CMP_IDX + 1;
  localparam int CNT_W = $clog2(SAT + 1);

  logic             active, accept;
  logic [CNT_W-1:0] idx;
  logic             enc, cmp_hit, cmp;
  ratio_e           ratio_nxt;
  logic             done_q, done_eff;
  logic [1:0]       ratio_q;
  logic             vld_q, err_q;

  word_idx_ctr #(.SAT(SAT), .CNT_W(CNT_W)) u_ctr (
    .clk_i, .rst_ni, .sof_i, .eof_i, .valid_i,
    .active_o(active), .accept_o(accept), .idx_o(idx)
  );

  hdr_field_cap #(
    .DATA_W(DATA_W), .ENC_IDX(ENC_IDX), .CMP_IDX(CMP_IDX),
    .ENC_LSB(ENC_LSB), .ENC_W(ENC_W), .CMP_BIT(CMP_BIT), .CNT_W(CNT_W)
  ) u_cap (
    .clk_i, .rst_ni, .sof_i, .accept_i(accept), .idx_i(idx), .data_i,
    .enc_o(enc), .cmp_hit_o(cmp_hit), .cmp_o(cmp)
  );

  ratio_map u_map (.enc_i(enc), .cmp_i(cmp), .wide_i(wide_i), .ratio_o(ratio_nxt));

  assign done_eff = sof_i ? 1'b0 : done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      ratio_q <= 2'(RATIO_X1);
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      vld_q <= cmp_hit;
      err_q <= eof_i && active && !done_eff && !cmp_hit;
      if (cmp_hit) begin
        ratio_q <= 2'(ratio_nxt);
        done_q  <= 1'b1;
      end else if (sof_i) begin
        done_q  <= 1'b0;
      end
    end
  end

  assign ratio_o     = ratio_q;
  assign ratio_vld_o = vld_q;
  assign err_o       = err_q;

  // R7
  vld_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ratio_vld_o && err_o));

  // R6
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ratio_vld_o |-> $stable(ratio_o));

  // R6
  vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_vld_o |=> !ratio_vld_o);
endmodule

// File: tb/cfg_hdr_inspect_tb_top.sv
module cfg_hdr_inspect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, eof = 1'b0, valid = 1'b0, wide = 1'b0;
  logic [31:0] data = '0;
  logic [1:0]  ratio;
  logic        ratio_vld, err;

  int n_chk = 0, n_bad = 0;
  int got_vld, got_err, vld_idx;
  logic [1:0] got_ratio;
  bit done = 0;

  localparam logic [31:0] FILL = 32'h0000_000C; // would read as encrypted and compressed
  // {enc[1:0], cmp_bit1, wide, expected code}
  localparam logic [5:0] VEC [8] = '{
    {2'b00, 1'b1, 1'b0, 2'd0}, {2'b00, 1'b1, 1'b1, 2'd0},
    {2'b01, 1'b1, 1'b0, 2'd1}, {2'b10, 1'b1, 1'b1, 2'd2},
    {2'b00, 1'b0, 1'b0, 2'd2}, {2'b00, 1'b0, 1'b1, 2'd3},
    {2'b11, 1'b0, 1'b0, 2'd2}, {2'b01, 1'b0, 1'b1, 2'd3}
  };

  always #4 clk = ~clk;

  cfg_hdr_inspect dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .eof_i(eof), .valid_i(valid),
    .data_i(data), .wide_i(wide), .ratio_o(ratio), .ratio_vld_o(ratio_vld), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sample(input int i);
    @(posedge clk); #1;
    if (ratio_vld) begin got_vld++; vld_idx = i; got_ratio = ratio; end
    if (err) got_err++;
  endtask

  // words; enc word; cmp word; width at word 229 (opposite elsewhere); eof on last word; idle gap
  task automatic run_img(input int n, input logic [31:0] ew, input logic [31:0] cw,
                         input logic w, input bit eof_last, input bit gap, input bit do_eof);
    got_vld = 0; got_err = 0; vld_idx = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sof = (i == 0); valid = 1'b1;
      data = (i == 69) ? ew : (i == 229) ? cw : FILL;
      wide = (i == 229) ? w : ~w;
      eof = eof_last && (i == n - 1);
      sample(i);
      if (gap) begin
        @(negedge clk); sof = 0; valid = 0; eof = 0; data = FILL;
        sample(-2);
      end
    end
    @(negedge clk);
    sof = 0; valid = 0; wide = ~w; eof = do_eof && !eof_last;
    sample(-1);
    @(negedge clk); eof = 0;
    sample(-1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    chk(ratio == 0 && !ratio_vld && !err, "R1 in reset", {ratio, ratio_vld, err}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(ratio == 0 && !ratio_vld && !err, "R1 after reset", {ratio, ratio_vld, err}, 0);

    // R2/R9: words and eof without an open image
    @(negedge clk); valid = 1; data = FILL;
    repeat (240) @(negedge clk);
    eof = 1; valid = 0;
    @(posedge clk); #1;
    chk(!ratio_vld && !err, "R9 no open image", {ratio_vld, err}, 0);
    @(negedge clk); eof = 0;
    @(posedge clk); #1;
    chk(!ratio_vld && !err && ratio == 0, "R9 no open image later", {ratio, ratio_vld, err}, 0);

    // R5/R3/R4/R10/R6 table
    foreach (VEC[k]) begin
      run_img(240, {28'h0, VEC[k][5:4], 2'b00}, VEC[k][3] ? 32'h2 : 32'h0, VEC[k][2], 0, 0, 1);
      chk(got_ratio == VEC[k][1:0], $sformatf("R5 vec %0d", k), got_ratio, VEC[k][1:0]);
      chk(got_vld == 1 && vld_idx == 229, $sformatf("R6 vec %0d", k), vld_idx, 229);
      chk(got_err == 0 && ratio == VEC[k][1:0], $sformatf("R9 vec %0d", k), got_err, 0);
    end

    // R3: other bits of word 69 ignored
    run_img(240, 32'hFFFF_FFF3, 32'h2, 1'b0, 0, 0, 1);
    chk(got_ratio == 0, "R3 non-flag bits", got_ratio, 0);

    // R2: idle gaps between words
    run_img(232, 32'h4, 32'h2, 1'b0, 0, 1, 1);
    chk(got_vld == 1 && vld_idx == 229 && got_ratio == 1, "R2 gaps", vld_idx, 229);

    // R2: sof restarts mid image (first image left open)
    run_img(150, 32'h0, 32'h0, 1'b1, 0, 0, 0);
    chk(got_vld == 0 && got_err == 0, "R2 partial", got_vld + got_err, 0);
    run_img(231, 32'h0, 32'h0, 1'b0, 0, 0, 1);
    chk(got_vld == 1 && vld_idx == 229 && got_ratio == 2, "R2 restart", vld_idx, 229);

    // R8: eof on word 229
    run_img(230, 32'h8, 32'h2, 1'b1, 1, 0, 1);
    chk(got_vld == 1 && got_err == 0 && got_ratio == 2, "R8 eof on last header word", got_err, 0);

    // R7: eof on word 228
    run_img(229, 32'h0, 32'h0, 1'b1, 1, 0, 1);
    chk(got_err == 1 && got_vld == 0, "R7 eof on word 228", got_err, 1);
    chk(ratio == 2, "R7 ratio kept", ratio, 2);

    // R7: eof after 100 words, separate cycle
    run_img(100, 32'h0, 32'h0, 1'b0, 0, 0, 1);
    chk(got_err == 1 && got_vld == 0, "R7 short image", got_err, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule